// File: doc/BRIEF.md
# Timer Host Register Port

This block is the host-side register front end of a three-channel interval timer. A host reaches it over an 8-bit data bus. It uses a select, a write strobe, a read strobe and a 2-bit address. Addresses 0 to 2 reach the count ports of channels 0 to 2, and address 3 reaches a shared control port. A control byte written to the control port gives one channel its operating mode, its BCD/binary flag and its byte access format. The mode and the flag are passed on unchanged to the counting logic, which lies outside this block.

Count bytes written to a channel port are assembled into a 16-bit initial count. The count is handed to the channel with a one-cycle load strobe once the last byte of the programmed format has arrived. Reads from a channel port return bytes of that channel's live count, or of a frozen snapshot. The snapshot is taken by a latch command and is held until the host has read it out. The host can therefore sample a running count without disturbing it.

Top module: `tmr_host_port`

## Requirements
- R1: A control byte written at address 3 is decoded as: bits 7:6 channel, bits 5:4 access format, bits 3:1 mode, bit 0 BCD flag. When the format is not 00, the channel's mode and BCD outputs take the written values one cycle later. A channel field of 11 changes nothing.
- R2: Addresses 0, 1 and 2 reach channels 0, 1 and 2, and address 3 is the control port. A read at address 3 returns 8'h00.
- R3: Format 01 (low byte only): each count write loads {8'h00, byte}, and the channel's load strobe is high for the one cycle after the write. Reads return the low byte.
- R4: Format 10 (high byte only): each count write loads {byte, 8'h00} with a one-cycle load strobe. Reads return the high byte.
- R5: Format 11 (low then high): the first count byte raises no strobe and leaves the loaded value unchanged. The second byte loads {second, first} with a one-cycle strobe. Reads alternate between the low byte and the high byte, starting with the low byte.
- R6: Writing a control byte to a channel resets both its write byte order and its read byte order, so the next access is the low byte.
- R7: Count writes to a channel that has had no control byte since reset are ignored: no load strobe is raised.
- R8: A control byte with format 00 is a latch command. It copies the channel's current count into a snapshot, and reads return the snapshot while the count keeps changing. The channel's mode and format stay as they were.
- R9: The snapshot is released after the last byte of the channel's format has been read. Later reads follow the live count.
- R10: A latch command on a channel whose snapshot is still unread is ignored.
- R11: Each channel's snapshot is independent. Latching and reading one channel leaves the snapshot of another channel intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus cycle select |
| bus_wr | input | 1 | Write strobe (takes priority over a read in the same cycle) |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Port address: 0 to 2 for channels, 3 for control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed port (combinational) |
| cnt_in | input | 48 | Live count of each channel, channel 0 in bits 15:0 |
| ch_mode | output | 9 | Mode of each channel, 3 bits per channel |
| ch_bcd | output | 3 | BCD flag of each channel |
| load_val | output | 48 | Assembled initial count of each channel |
| load_stb | output | 3 | One-cycle new-count notification per channel |

## Verification
The bench sweeps every channel through all three byte formats. For each format it writes several computed count values. This separates the byte placement of low-only and high-only loads from the pairing of bytes in two-byte loads, and it shows that a first byte on its own never reaches the channel. Reads are taken while the bench drives live counts that differ from the written ones, so a read path that returns the wrong byte or the wrong source stands out. Directed sequences then cover the following: a write before any control byte, a control byte that interrupts a half-finished write or read, a second latch command while a snapshot is unread, and snapshots held on two channels at once while the live counts move.

// File: rtl/tmr_bus_pkg.sv
package tmr_bus_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int MODE_W = 3;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LO    = 2'b01,
        ACC_HI    = 2'b10,
        ACC_BOTH  = 2'b11
    } acc_e;

    typedef struct packed {
        logic [1:0]        chan;
        acc_e              acc;
        logic [MODE_W-1:0] mode;
        logic              bcd;
    } cw_t;

endpackage

// File: rtl/tmr_cw_decode.sv
module tmr_cw_decode
    import tmr_bus_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic [BYTE_W-1:0] cw_byte,
    output cw_t               cw,
    output logic [NCH-1:0]    hit_oh,
    output logic              is_latch
);

    always_comb begin
        cw       = cw_t'(cw_byte);
        hit_oh   = '0;
        is_latch = (cw.acc == ACC_LATCH);
        for (int i = 0; i < NCH; i++) begin
            if (int'(cw.chan) == i) hit_oh[i] = 1'b1;
        end
    end

endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
    import tmr_bus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cw_hit,
    input  logic              latch_hit,
    input  acc_e              cw_acc,
    input  logic [MODE_W-1:0] cw_mode,
    input  logic              cw_bcd,
    input  logic              wr_hit,
    input  logic              rd_hit,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt_in,
    output logic [MODE_W-1:0] mode,
    output logic              bcd,
    output logic [CNT_W-1:0]  load_val,
    output logic              load_stb,
    output logic [BYTE_W-1:0] rd_byte
);

    typedef struct packed {
        acc_e              acc;
        logic [MODE_W-1:0] mode;
        logic              bcd;
        logic              wr_hi;
        logic              rd_hi;
        logic [BYTE_W-1:0] lo_hold;
        logic              held;
        logic [CNT_W-1:0]  snap;
        logic [CNT_W-1:0]  load;
        logic              stb;
    } chan_st_t;

    chan_st_t st_q, st_d;
    logic [CNT_W-1:0] rd_src;
    logic             rd_hi_sel;

    always_comb begin
        st_d      = st_q;
        st_d.stb  = 1'b0;
        rd_src    = st_q.held ? st_q.snap : cnt_in;
        rd_hi_sel = (st_q.acc == ACC_HI) || ((st_q.acc == ACC_BOTH) && st_q.rd_hi);
        rd_byte   = rd_hi_sel ? rd_src[CNT_W-1:BYTE_W] : rd_src[BYTE_W-1:0];

        if (cw_hit) begin
            st_d.acc   = cw_acc;
            st_d.mode  = cw_mode;
            st_d.bcd   = cw_bcd;
            st_d.wr_hi = 1'b0;
            st_d.rd_hi = 1'b0;
            st_d.held  = 1'b0;
        end else if (latch_hit) begin
            if (!st_q.held) begin
                st_d.held = 1'b1;
                st_d.snap = cnt_in;
            end
        end else if (wr_hit) begin
            case (st_q.acc)
                ACC_LO: begin
                    st_d.load = {{BYTE_W{1'b0}}, wdata};
                    st_d.stb  = 1'b1;
                end
                ACC_HI: begin
                    st_d.load = {wdata, {BYTE_W{1'b0}}};
                    st_d.stb  = 1'b1;
                end
                ACC_BOTH: begin
                    if (!st_q.wr_hi) begin
                        st_d.lo_hold = wdata;
                        st_d.wr_hi   = 1'b1;
                    end else begin
                        st_d.load  = {wdata, st_q.lo_hold};
                        st_d.stb   = 1'b1;
                        st_d.wr_hi = 1'b0;
                    end
                end
                default: ;
            endcase
        end else if (rd_hit) begin
            case (st_q.acc)
                ACC_LO, ACC_HI: st_d.held = 1'b0;
                ACC_BOTH: begin
                    if (st_q.rd_hi) begin
                        st_d.held  = 1'b0;
                        st_d.rd_hi = 1'b0;
                    end else begin
                        st_d.rd_hi = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{acc: ACC_LATCH, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode     = st_q.mode;
    assign bcd      = st_q.bcd;
    assign load_val = st_q.load;
    assign load_stb = st_q.stb;

endmodule

// File: rtl/tmr_host_port.sv
module tmr_host_port
    import tmr_bus_pkg::*;
#(
    parameter int NCH = 3,
    localparam int AW = 2,
    localparam logic [AW-1:0] CTL_ADDR = 2'b11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [AW-1:0]         bus_addr,
    input  logic [BYTE_W-1:0]     bus_wdata,
    output logic [BYTE_W-1:0]     bus_rdata,
    input  logic [NCH*CNT_W-1:0]  cnt_in,
    output logic [NCH*MODE_W-1:0] ch_mode,
    output logic [NCH-1:0]        ch_bcd,
    output logic [NCH*CNT_W-1:0]  load_val,
    output logic [NCH-1:0]        load_stb
);

    cw_t            cw;
    logic [NCH-1:0] cw_oh;
    logic           cw_is_latch;
    logic           wr_cyc, rd_cyc, ctl_wr;
    logic [BYTE_W-1:0] rd_byte [NCH];

    assign wr_cyc = bus_sel && bus_wr;
    assign rd_cyc = bus_sel && bus_rd && !bus_wr;
    assign ctl_wr = wr_cyc && (bus_addr == CTL_ADDR);

    tmr_cw_decode #(.NCH(NCH)) u_dec (
        .cw_byte  (bus_wdata),
        .cw       (cw),
        .hit_oh   (cw_oh),
        .is_latch (cw_is_latch)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        tmr_chan_regs u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .cw_hit    (ctl_wr && cw_oh[g] && !cw_is_latch),
            .latch_hit (ctl_wr && cw_oh[g] && cw_is_latch),
            .cw_acc    (cw.acc),
            .cw_mode   (cw.mode),
            .cw_bcd    (cw.bcd),
            .wr_hit    (wr_cyc && (bus_addr == AW'(g))),
            .rd_hit    (rd_cyc && (bus_addr == AW'(g))),
            .wdata     (bus_wdata),
            .cnt_in    (cnt_in[g*CNT_W +: CNT_W]),
            .mode      (ch_mode[g*MODE_W +: MODE_W]),
            .bcd       (ch_bcd[g]),
            .load_val  (load_val[g*CNT_W +: CNT_W]),
            .load_stb  (load_stb[g]),
            .rd_byte   (rd_byte[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == AW'(i)) bus_rdata = rd_byte[i];
        end
    end

endmodule

// File: rtl/tmr_host_port_chk.sv
module tmr_host_port_chk
    import tmr_bus_pkg::*;
#(
    parameter int NCH = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_sel,
    input logic                  bus_wr,
    input logic [1:0]            bus_addr,
    input logic [BYTE_W-1:0]     bus_wdata,
    input logic [NCH*MODE_W-1:0] ch_mode,
    input logic [NCH-1:0]        ch_bcd,
    input logic [NCH*CNT_W-1:0]  load_val,
    input logic [NCH-1:0]        load_stb
);

    // R3: a single bus write notifies at most one channel
    p_one_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_stb));

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        // R2: a load strobe only follows a write to that channel's address
        p_load_from_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
            load_stb[g] |-> $past(bus_sel && bus_wr && (bus_addr == 2'(g))));

        // R1: a non-latch control byte sets mode and BCD flag
        p_cw_applies_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_sel && bus_wr && (bus_addr == 2'b11) && (bus_wdata[7:6] == 2'(g))
             && (bus_wdata[5:4] != 2'b00))
            |=> (ch_mode[g*MODE_W +: MODE_W] == $past(bus_wdata[3:1]))
                && (ch_bcd[g] == $past(bus_wdata[0])));

        // R8: mode holds unless the control port is written
        p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !(bus_sel && bus_wr && (bus_addr == 2'b11))
            |=> $stable(ch_mode[g*MODE_W +: MODE_W]));

        // R5: the loaded count changes only together with its strobe
        p_load_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !load_stb[g] |-> $stable(load_val[g*CNT_W +: CNT_W]));
    end

endmodule

bind tmr_host_port tmr_host_port_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/tb_tmr_host_port.sv
module tb_tmr_host_port;

    localparam int NCH = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [15:0] live [NCH];
    logic [NCH*16-1:0] cnt_in;
    logic [NCH*3-1:0] ch_mode;
    logic [NCH-1:0] ch_bcd;
    logic [NCH*16-1:0] load_val;
    logic [NCH-1:0] load_stb;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    assign cnt_in = {live[2], live[1], live[0]};

    tmr_host_port #(.NCH(NCH)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_in(cnt_in), .ch_mode(ch_mode), .ch_bcd(ch_bcd),
        .load_val(load_val), .load_stb(load_stb)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    function automatic logic [7:0] cw(input int ch, input int f, input int m, input int b);
        return {2'(ch), 2'(f), 3'(m), 1'(b)};
    endfunction

    initial begin
        #(200000 * 4);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [7:0]  rb;
        logic [15:0] v;
        logic [15:0] prev_load [NCH];
        logic [8:0]  mode_snap;
        for (int i = 0; i < NCH; i++) begin
            live[i] = 16'h0;
            prev_load[i] = 16'h0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        check("R1 reset mode", 16'(ch_mode), 16'h0);
        check("R3 reset strobe", 16'(load_stb), 16'h0);

        // R7: count write before any control byte
        bus_write(2'd0, 8'h55);
        check("R7 unprogrammed write", 16'(load_stb), 16'h0);

        // R2: control port reads as zero
        live[0] = 16'h7777;
        bus_read(2'd3, rb);
        check("R2 control read", 16'(rb), 16'h0);

        // sweep of channels, formats and values
        for (int ch = 0; ch < NCH; ch++) begin
            for (int f = 1; f < 4; f++) begin
                int m, b;
                m = (ch * 3 + f) % 8;
                b = (ch + f) % 2;
                bus_write(2'd3, cw(ch, f, m, b));
                check("R1 mode", 16'(ch_mode[ch*3 +: 3]), 16'(m));
                check("R1 bcd", 16'(ch_bcd[ch]), 16'(b));
                for (int k = 0; k < 4; k++) begin
                    v = 16'((k + 1) * 16'h1357) ^ 16'(ch << 12);
                    if (f == 1) begin
                        bus_write(2'(ch), v[7:0]);
                        check("R3 strobe", 16'(load_stb), 16'(1 << ch));
                        check("R3 value", load_val[ch*16 +: 16], {8'h00, v[7:0]});
                        prev_load[ch] = {8'h00, v[7:0]};
                    end else if (f == 2) begin
                        bus_write(2'(ch), v[15:8]);
                        check("R4 strobe", 16'(load_stb), 16'(1 << ch));
                        check("R4 value", load_val[ch*16 +: 16], {v[15:8], 8'h00});
                        prev_load[ch] = {v[15:8], 8'h00};
                    end else begin
                        bus_write(2'(ch), v[7:0]);
                        check("R5 first byte strobe", 16'(load_stb), 16'h0);
                        check("R5 first byte value", load_val[ch*16 +: 16], prev_load[ch]);
                        bus_write(2'(ch), v[15:8]);
                        check("R5 strobe", 16'(load_stb), 16'(1 << ch));
                        check("R5 value", load_val[ch*16 +: 16], v);
                        prev_load[ch] = v;
                    end
                    live[ch] = v ^ 16'hA5C3;
                    if (f == 1) begin
                        bus_read(2'(ch), rb);
                        check("R3 read", 16'(rb), 16'(live[ch][7:0]));
                    end else if (f == 2) begin
                        bus_read(2'(ch), rb);
                        check("R4 read", 16'(rb), 16'(live[ch][15:8]));
                    end else begin
                        bus_read(2'(ch), rb);
                        check("R5 read low", 16'(rb), 16'(live[ch][7:0]));
                        bus_read(2'(ch), rb);
                        check("R5 read high", 16'(rb), 16'(live[ch][15:8]));
                    end
                end
            end
        end

        // R1: channel field 11 changes nothing
        mode_snap = ch_mode;
        bus_write(2'd3, 8'hFF);
        check("R1 channel 11 ignored", 16'(ch_mode), 16'(mode_snap));

        // R6: control byte resets write order
        bus_write(2'd2, 8'h12);
        bus_write(2'd3, cw(2, 3, 5, 0));
        bus_write(2'd2, 8'h34);
        check("R6 write order strobe", 16'(load_stb), 16'h0);
        bus_write(2'd2, 8'h56);
        check("R6 write order value", load_val[32 +: 16], 16'h5634);
        // R6: control byte resets read order
        live[2] = 16'hBEEF;
        bus_read(2'd2, rb);
        check("R6 read low", 16'(rb), 16'h00EF);
        bus_write(2'd3, cw(2, 3, 5, 0));
        bus_read(2'd2, rb);
        check("R6 read order reset", 16'(rb), 16'h00EF);

        // R8, R10, R9 on channel 1
        bus_write(2'd3, cw(1, 3, 2, 0));
        live[1] = 16'hABCD;
        bus_write(2'd3, cw(1, 0, 0, 0));
        check("R8 latch keeps mode", 16'(ch_mode[3 +: 3]), 16'd2);
        live[1] = 16'h1111;
        bus_write(2'd3, cw(1, 0, 0, 0));
        live[1] = 16'h2222;
        bus_read(2'd1, rb);
        check("R8 snapshot low", 16'(rb), 16'h00CD);
        bus_read(2'd1, rb);
        check("R10 second latch ignored", 16'(rb), 16'h00AB);
        live[1] = 16'h3344;
        bus_read(2'd1, rb);
        check("R9 released low", 16'(rb), 16'h0044);
        bus_read(2'd1, rb);
        check("R9 released high", 16'(rb), 16'h0033);

        // R11: independent snapshots on channels 0 and 2
        bus_write(2'd3, cw(0, 1, 0, 0));
        bus_write(2'd3, cw(2, 2, 0, 0));
        live[0] = 16'h0102;
        live[2] = 16'h0304;
        bus_write(2'd3, cw(0, 0, 0, 0));
        bus_write(2'd3, cw(2, 0, 0, 0));
        live[0] = 16'hF0F0;
        live[2] = 16'hE0E0;
        bus_read(2'd2, rb);
        check("R11 channel 2 snapshot", 16'(rb), 16'h0003);
        bus_read(2'd0, rb);
        check("R11 channel 0 snapshot", 16'(rb), 16'h0002);
        bus_read(2'd0, rb);
        check("R9 single-byte release", 16'(rb), 16'h00F0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule